// File: doc/BRIEF.md
# I2C Slave Address Matcher and Write Receiver

This block is the receive side of an I2C target device. It takes SCL and SDA after the pad buffers, resynchronises both into the system clock domain, and finds bus events by comparing each synchronised level with its value one cycle earlier. From those events it detects START and STOP conditions, shifts in the address byte and compares it with a programmable own address. When the address matches and the direction bit says write, the block pulls SDA low for the acknowledge clock. It then takes in the data bytes that follow and acknowledges each one.

Every event of interest sets a flag and writes a status code. The host reads the code and the data register, then pulses a clear input. Recognition of the broadcast address (all zeros) is switched on by the lowest bit of the own-address word. The system clock must run at least sixteen times faster than SCL.

Top module: `i2c_slave_rx`

## Requirements
- R1: A falling SDA while SCL is high is a START and begins address reception. A rising SDA while SCL is high is a STOP: it returns the block to idle and releases SDA. Bits clocked in while idle are ignored and not acknowledged.
- R2: The address byte arrives MSB first, sampled on SCL rising edges. Bits 7:1 are the address and bit 0 is the direction, where 0 means write. The block acknowledges when bits 7:1 equal `own_addr_i[7:1]`, that value is non-zero, and the direction is write. It then reports status 1.
- R3: The all-zero byte (address 0, write) is acknowledged only when `own_addr_i[0]` is 1, and it reports status 2. When `own_addr_i[0]` is 0 it is not acknowledged and produces no flag.
- R4: To acknowledge, `sda_pull_o` rises on the first SCL fall after the eighth SCL rise of a byte and falls on the next SCL fall. It changes at no other time except on START or STOP.
- R5: After a matching address, each following byte, received MSB first, is loaded into `data_o` on its eighth SCL rise. The byte is acknowledged and reports status 3.
- R6: An address that does not match, or that carries the read direction, is not acknowledged and raises no flag. All later bits are ignored until the next START or STOP.
- R7: A STOP reports status 4 only if the block acknowledged an address since the last START. Any other STOP leaves the flag alone.
- R8: A repeated START at any point, including in the middle of a byte, restarts address reception from the first bit.
- R9: Each report sets `flag_o` and writes `status_o`. The report is made on the SCL fall that ends the acknowledge clock, or on the STOP. `flag_o` stays set until a `flag_clr_i` pulse, and a report in the same cycle as the clear wins. `status_o` holds the last code reported.
- R10: After reset, `sda_pull_o`, `flag_o`, `status_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| own_addr_i | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| flag_clr_i | input | 1 | One-cycle pulse clearing the event flag |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| flag_o | output | 1 | Event flag |
| status_o | output | 3 | 0 none, 1 own write, 2 general call, 3 data, 4 STOP |
| data_o | output | 8 | Last data byte received |

## Verification
The assertions assume that the bus never moves SCL and SDA in a way the synchroniser cannot resolve. Each line level must last several system clocks, so that any SCL rise, SCL fall, START or STOP appears as one clean single-cycle event. The bench keeps to this by holding every SCL phase for ten system clocks. It changes SDA only while SCL is low, except where it deliberately forms a START or STOP. The SDA the block sees is the open-drain AND of the stimulus and `sda_pull_o`, so acknowledges are observed on the wire itself.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

   localparam int BYTE_W  = 8;
   localparam int STAT_W  = 3;
   localparam int BITCNT_W = $clog2(BYTE_W);

   typedef enum logic [STAT_W-1:0] {
      RX_ST_NONE  = 3'd0,
      RX_ST_OWN_W = 3'd1,
      RX_ST_GCALL = 3'd2,
      RX_ST_DATA  = 3'd3,
      RX_ST_STOP  = 3'd4
   } rx_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACK_WAIT,
      PH_ACK_HOLD,
      PH_DATA,
      PH_IGNORE
   } rx_phase_e;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic q_d_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o   = chain_q[STAGES-1];
   assign q_d_o = last_q;

endmodule

// File: rtl/i2c_rx_events.sv
module i2c_rx_events (
   input  logic scl_s_i,
   input  logic scl_d_i,
   input  logic sda_s_i,
   input  logic sda_d_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   logic scl_held_high;

   assign scl_held_high = scl_s_i & scl_d_i;
   assign start_o = scl_held_high & sda_d_i & ~sda_s_i;
   assign stop_o  = scl_held_high & ~sda_d_i & sda_s_i;
   assign rise_o  = scl_s_i & ~scl_d_i;
   assign fall_o  = ~scl_s_i & scl_d_i;

endmodule

// File: rtl/i2c_rx_addr_match.sv
module i2c_rx_addr_match
   import i2c_rx_pkg::*;
#(
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [BYTE_W-1:0] own_i,
   output logic              own_hit_o,
   output logic              gc_hit_o
);

   logic write_dir;
   logic addr_zero;

   assign write_dir = ~byte_i[0];
   assign addr_zero = (byte_i[BYTE_W-1:1] == '0);
   assign own_hit_o = write_dir && !addr_zero && (byte_i[BYTE_W-1:1] == own_i[BYTE_W-1:1]);

   if (GCALL_SUPPORT) begin : g_gcall
      assign gc_hit_o = write_dir && addr_zero && own_i[0];
   end else begin : g_no_gcall
      assign gc_hit_o = 1'b0;
   end

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
   import i2c_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sda_i,
   input  logic              own_hit_i,
   input  logic              gc_hit_i,
   input  logic              flag_clr_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              drive_o,
   output logic              flag_o,
   output logic [STAT_W-1:0] status_o,
   output logic [BYTE_W-1:0] data_o
);

   localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

   rx_phase_e         phase_q;
   rx_status_e        status_q, pend_q;
   logic [BITCNT_W-1:0] cnt_q;
   logic [BYTE_W-1:0] shreg_q, data_q;
   logic              drive_q, flag_q, sel_q;

   assign byte_o = {shreg_q[BYTE_W-2:0], sda_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         status_q <= RX_ST_NONE;
         pend_q   <= RX_ST_NONE;
         cnt_q    <= '0;
         shreg_q  <= '0;
         data_q   <= '0;
         drive_q  <= 1'b0;
         flag_q   <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         if (flag_clr_i) flag_q <= 1'b0;
         if (start_i) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            drive_q <= 1'b0;
            sel_q   <= 1'b0;
         end else if (stop_i) begin
            phase_q <= PH_IDLE;
            drive_q <= 1'b0;
            sel_q   <= 1'b0;
            if (sel_q) begin
               flag_q   <= 1'b1;
               status_q <= RX_ST_STOP;
            end
         end else begin
            unique case (phase_q)
               PH_ADDR, PH_DATA: begin
                  if (rise_i) begin
                     shreg_q <= byte_o;
                     if (cnt_q == LAST_BIT) begin
                        cnt_q <= '0;
                        if (phase_q == PH_DATA) begin
                           data_q  <= byte_o;
                           pend_q  <= RX_ST_DATA;
                           phase_q <= PH_ACK_WAIT;
                        end else if (own_hit_i) begin
                           pend_q  <= RX_ST_OWN_W;
                           phase_q <= PH_ACK_WAIT;
                        end else if (gc_hit_i) begin
                           pend_q  <= RX_ST_GCALL;
                           phase_q <= PH_ACK_WAIT;
                        end else begin
                           phase_q <= PH_IGNORE;
                        end
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               PH_ACK_WAIT: begin
                  if (fall_i) begin
                     drive_q <= 1'b1;
                     phase_q <= PH_ACK_HOLD;
                  end
               end
               PH_ACK_HOLD: begin
                  if (fall_i) begin
                     drive_q  <= 1'b0;
                     phase_q  <= PH_DATA;
                     cnt_q    <= '0;
                     sel_q    <= 1'b1;
                     flag_q   <= 1'b1;
                     status_q <= pend_q;
                  end
               end
               PH_IDLE, PH_IGNORE: ;
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign drive_o  = drive_q;
   assign flag_o   = flag_q;
   assign status_o = status_q;
   assign data_o   = data_q;

   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (phase_q == PH_ADDR) && (cnt_q == '0)) else $error("restart"); // R8

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (phase_q == PH_IDLE) && !drive_q) else $error("stop"); // R1

   AST_PULL_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drive_q) |-> $past(fall_i || start_i || stop_i)) else $error("pull edge"); // R4

   AST_NO_PULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IGNORE) |-> !drive_q) else $error("pull ignored"); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_i) |=> flag_q) else $error("flag"); // R9

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
   import i2c_rx_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [BYTE_W-1:0] own_addr_i,
   input  logic              flag_clr_i,
   output logic              sda_pull_o,
   output logic              flag_o,
   output logic [STAT_W-1:0] status_o,
   output logic [BYTE_W-1:0] data_o
);

   localparam int LINES   = 2;
   localparam int IDX_SCL = 1;
   localparam int IDX_SDA = 0;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0]  raw, line_s, line_d;
   logic              ev_start, ev_stop, ev_rise, ev_fall;
   logic              own_hit, gc_hit;
   logic [BYTE_W-1:0] cand_byte;

   assign raw[IDX_SCL] = scl_i;
   assign raw[IDX_SDA] = sda_i;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw[g]),
         .q_o   (line_s[g]),
         .q_d_o (line_d[g])
      );
   end

   i2c_rx_events u_events (
      .scl_s_i (line_s[IDX_SCL]),
      .scl_d_i (line_d[IDX_SCL]),
      .sda_s_i (line_s[IDX_SDA]),
      .sda_d_i (line_d[IDX_SDA]),
      .start_o (ev_start),
      .stop_o  (ev_stop),
      .rise_o  (ev_rise),
      .fall_o  (ev_fall)
   );

   i2c_rx_addr_match #(.GCALL_SUPPORT(GCALL_SUPPORT)) u_match (
      .byte_i    (cand_byte),
      .own_i     (own_addr_i),
      .own_hit_o (own_hit),
      .gc_hit_o  (gc_hit)
   );

   i2c_rx_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (ev_start),
      .stop_i     (ev_stop),
      .rise_i     (ev_rise),
      .fall_i     (ev_fall),
      .sda_i      (line_s[IDX_SDA]),
      .own_hit_i  (own_hit),
      .gc_hit_i   (gc_hit),
      .flag_clr_i (flag_clr_i),
      .byte_o     (cand_byte),
      .drive_o    (sda_pull_o),
      .flag_o     (flag_o),
      .status_o   (status_o),
      .data_o     (data_o)
   );

endmodule

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;

   localparam int NS = 2;    // synchroniser depth of the DUT default
   localparam int H  = 10;   // system clocks per SCL phase

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [7:0] own = 8'h00;
   logic       flag_clr = 1'b0;
   logic       sda_pull, flag;
   logic [2:0] status;
   logic [7:0] data;
   wire        sda_bus = m_sda & ~sda_pull;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;   // 100 MHz

   i2c_slave_rx dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .own_addr_i (own),
      .flag_clr_i (flag_clr),
      .sda_pull_o (sda_pull),
      .flag_o     (flag),
      .status_o   (status),
      .data_o     (data)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference, compared every clock ----------------
   logic [7:0] hs, hd;
   int  md, mcnt, msh, mpend, mstat, mdata, b;
   bit  msel, mdrv, mflag, cs, ps, cd, pd, ev_st, ev_sp, ev_rs, ev_fl;

   always @(negedge clk) begin
      if (!rst_n) begin
         hs = '1; hd = '1; md = 0; mcnt = 0; msh = 0; mpend = 0;
         mstat = 0; mdata = 0; msel = 0; mdrv = 0; mflag = 0;
      end else begin
         chk("R4", "pull", sda_pull, mdrv);
         chk("R9", "flag", flag, mflag);
         chk("R7", "status", status, mstat);
         chk("R5", "data", data, mdata);
         hs = {hs[6:0], scl};
         hd = {hd[6:0], sda_bus};
         cs = hs[NS]; ps = hs[NS+1]; cd = hd[NS]; pd = hd[NS+1];
         ev_st = cs && ps && pd && !cd;
         ev_sp = cs && ps && !pd && cd;
         ev_rs = cs && !ps;
         ev_fl = !cs && ps;
         if (flag_clr) mflag = 0;
         if (ev_st) begin
            md = 1; mcnt = 0; mdrv = 0; msel = 0;
         end else if (ev_sp) begin
            md = 0; mdrv = 0;
            if (msel) begin mflag = 1; mstat = 4; end
            msel = 0;
         end else if ((md == 1 || md == 4) && ev_rs) begin
            b = ((msh << 1) | int'(cd)) & 255;
            msh = b;
            if (mcnt == 7) begin
               mcnt = 0;
               if (md == 4) begin
                  mdata = b; mpend = 3; md = 2;
               end else if (b[0] == 1'b0 && (b >> 1) != 0 && (b >> 1) == int'(own >> 1)) begin
                  mpend = 1; md = 2;
               end else if (b == 0 && own[0]) begin
                  mpend = 2; md = 2;
               end else begin
                  md = 5;
               end
            end else begin
               mcnt++;
            end
         end else if (md == 2 && ev_fl) begin
            mdrv = 1; md = 3;
         end else if (md == 3 && ev_fl) begin
            mdrv = 0; md = 4; mcnt = 0; msel = 1; mflag = 1; mstat = mpend;
         end
      end
   end

   // ---------------- bus driving ----------------
   task automatic wclk(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_start();
      m_sda = 1'b1; wclk(H); scl = 1'b1; wclk(H); m_sda = 1'b0; wclk(H); scl = 1'b0; wclk(H);
   endtask

   task automatic do_stop();
      m_sda = 1'b0; wclk(H); scl = 1'b1; wclk(H); m_sda = 1'b1; wclk(H);
   endtask

   task automatic send_bit(logic v);
      m_sda = v; wclk(H); scl = 1'b1; wclk(H); scl = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] v, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      m_sda = 1'b1; wclk(H); scl = 1'b1; wclk(H/2);
      acked = ~sda_bus;
      wclk(H/2); scl = 1'b0; wclk(5);
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; wclk(1); flag_clr = 1'b0; wclk(1);
   endtask

   initial begin
      logic ack;
      wclk(3);
      rst_n = 1'b1;
      wclk(2);
      chk("R10", "reset pull", sda_pull, 0);
      chk("R10", "reset flag", flag, 0);
      chk("R10", "reset status", status, 0);
      chk("R10", "reset data", data, 0);

      // own address 0x5A, general call enabled
      own = {7'h5A, 1'b1};
      do_start();
      send_byte(8'hB4, ack);
      chk("R2", "own addr ack", ack, 1);
      chk("R2", "own addr status", status, 1);
      chk("R9", "flag set", flag, 1);
      clear_flag();
      chk("R9", "flag cleared", flag, 0);
      send_byte(8'hC3, ack);
      chk("R5", "data ack", ack, 1);
      chk("R5", "data value", data, 8'hC3);
      send_byte(8'h3C, ack);
      chk("R5", "second data", data, 8'h3C);
      chk("R9", "status last code", status, 3);
      clear_flag();
      do_stop();
      wclk(5);
      chk("R7", "stop status", status, 4);
      chk("R7", "stop flag", flag, 1);
      clear_flag();

      // mismatch then ignored bytes
      do_start();
      send_byte(8'hB6, ack);
      chk("R6", "mismatch no ack", ack, 0);
      send_byte(8'hB4, ack);
      chk("R6", "ignored byte no ack", ack, 0);
      chk("R6", "ignored no flag", flag, 0);
      do_stop();
      wclk(5);
      chk("R7", "unaddressed stop no flag", flag, 0);

      // read direction
      do_start();
      send_byte(8'hB5, ack);
      chk("R6", "read dir no ack", ack, 0);
      do_stop();

      // general call enabled
      do_start();
      send_byte(8'h00, ack);
      chk("R3", "gcall ack", ack, 1);
      chk("R3", "gcall status", status, 2);
      send_byte(8'h81, ack);
      chk("R5", "gcall data", data, 8'h81);
      do_stop();
      wclk(5);
      chk("R7", "gcall stop", status, 4);
      clear_flag();

      // general call disabled
      own = {7'h5A, 1'b0};
      do_start();
      send_byte(8'h00, ack);
      chk("R3", "gcall disabled no ack", ack, 0);
      chk("R3", "gcall disabled no flag", flag, 0);
      do_stop();

      // repeated START mid-byte and after data
      own = {7'h5A, 1'b1};
      do_start();
      for (int i = 0; i < 4; i++) send_bit(i[0]);
      do_start();
      send_byte(8'hB4, ack);
      chk("R8", "restart mid-byte ack", ack, 1);
      send_byte(8'h55, ack);
      chk("R8", "data after restart", data, 8'h55);
      clear_flag();
      do_start();
      send_byte(8'h00, ack);
      chk("R8", "restart to gcall", status, 2);
      do_stop();
      clear_flag();

      // STOP mid-address, then bits without START
      do_start();
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      do_stop();
      scl = 1'b0; wclk(H);
      send_byte(8'hB4, ack);
      chk("R1", "idle bits ignored", ack, 0);
      chk("R1", "idle no flag", flag, 0);
      do_stop();
      wclk(10);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule